// File: doc/BRIEF.md
# Random Word Refill Controller

This block is a memory-mapped source of pseudo-random 32-bit words. A 64-bit linear feedback shift register starts stepping on the first clock after reset and keeps stepping every cycle, whether or not the block is enabled. Software sets a start bit in the control register. From then on a cadence sequencer takes one word from the register at a fixed interval of 256 cycles and pushes it into a 16-entry output queue. The word is the XOR of the upper and lower halves of the register.

Software polls the fill level in the status register and then reads the data register once for each word it wants. Each read pops one entry, and reads may be issued on consecutive cycles. Reading the data register while the queue is empty does not stall the bus. The read returns zero and sets a sticky error flag. If interrupts are enabled, the same read also raises a request line. Both the flag and the request stay set until software writes the clear bit.

The register bus is a simple single-cycle interface. A write takes effect at the clock edge where `wr_en` is sampled high. Read data is registered and appears on `rd_data` one cycle after `rd_en`, and it holds until the next read.

Top module: `rng_fill_ctrl`

## Requirements
- R1: After reset, `irq` is 0, `rd_data` is 0, the control register (byte offset 0x0) reads 0 and the status register (byte offset 0x4) reads 0.
- R2: While control bit 0 (start) is 0, no word enters the queue, so the status level field stays unchanged or falls.
- R3: When start is written from 0 to 1 at clock edge E, words are pushed at edges E+256, E+512, E+768 and so on. A push is seen in the status level one edge later.
- R4: The LFSR resets to 64'h0123_4567_89AB_CDEF and shifts left by one at every clock edge after reset. The bit shifted in is s[63]^s[62]^s[60]^s[59]. A word pushed at edge number n (counted from 0 at the first edge after reset) is the XOR of bits 63:32 and bits 31:0 of the state held just before that edge.
- R5: Status bits 12:8 give the number of stored words, from 0 to 16. Status bit 0 is 1 exactly when 16 words are stored.
- R6: At a push boundary where the queue is full, the push is skipped. Filling resumes at the first boundary after a read frees an entry.
- R7: A read of the data register (byte offset 0x8) while the queue is not empty pops the oldest word and returns it on `rd_data` one cycle later. Back-to-back reads return successive words in push order.
- R8: A read of the data register while the queue is empty returns 0, leaves the level unchanged and sets the sticky error flag, status bit 1.
- R9: An empty data read with control bit 1 (interrupt enable) set raises `irq`. When that bit is 0, `irq` stays low.
- R10: Writing 1 to control bit 2 clears `irq` and status bit 1. Until that write, both stay set. Bit 2 always reads back as 0.
- R11: Writing start back to 0 stops all further pushes. A later write of 1 restarts the cadence, so the next push comes 256 edges after the restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 4 | Byte offset of the register being accessed |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 32 | Registered read data, valid one cycle after `rd_en` |
| irq | output | 1 | Interrupt request raised by an empty data read |

## Verification
The checker assumes that a read strobe and a write strobe never arrive in the same cycle. It also takes as given that only the three defined offsets decide any behaviour. The bench tasks raise exactly one strobe for one cycle and then drop it, so every access is a single, isolated operation. Push timing depends on which edge carried the start write, so the bench records the index of that edge. It then places each status or data read on an exact edge around a 256-cycle boundary, either just before or just after the push.

// File: rtl/rng_fill_pkg.sv
package rng_fill_pkg;

    localparam int LFSR_W   = 64;
    localparam int WORD_W   = 32;
    localparam int CAD_W    = 8;
    localparam int ADDR_W   = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_DATA = 4'h8;

    localparam int CTL_START    = 0;
    localparam int CTL_IE       = 1;
    localparam int CTL_CLR      = 2;
    localparam int STAT_FULL    = 0;
    localparam int STAT_ERR     = 1;
    localparam int STAT_LVL_LSB = 8;

    typedef struct packed {
        logic              start;
        logic              ie;
        logic              err;
        logic              irq;
        logic [CAD_W-1:0]  cnt;
        logic [WORD_W-1:0] rdata;
    } ctl_state_t;

endpackage

// File: rtl/rng_lfsr64.sv
module rng_lfsr64 #(
    parameter logic [rng_fill_pkg::LFSR_W-1:0] SEED = 64'h0123_4567_89AB_CDEF
) (
    input  logic                            clk,
    input  logic                            rst_n,
    output logic [rng_fill_pkg::WORD_W-1:0] word
);
    import rng_fill_pkg::*;

    localparam int HALF = LFSR_W / 2;

    logic [LFSR_W-1:0] state_d, state_q;

    // Fibonacci form, polynomial x^64 + x^63 + x^61 + x^60 + 1
    always_comb begin
        state_d = {state_q[LFSR_W-2:0],
                   state_q[63] ^ state_q[62] ^ state_q[60] ^ state_q[59]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign word = state_q[LFSR_W-1:HALF] ^ state_q[HALF-1:0];

endmodule

// File: rtl/rng_word_fifo.sv
module rng_word_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]     mem_d [DEPTH];
    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_d, wr_q, rd_d, rd_q;
    logic [LVL_W-1:0] cnt_d, cnt_q;
    logic             push_ok, pop_ok;

    assign full  = (cnt_q == LVL_W'(DEPTH));
    assign empty = (cnt_q == '0);

    always_comb begin
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        mem_d   = mem_q;
        if (push_ok) mem_d[wr_q] = din;
        wr_d  = wr_q + PTR_W'(push_ok);
        rd_d  = rd_q + PTR_W'(pop_ok);
        cnt_d = cnt_q + LVL_W'(push_ok) - LVL_W'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            mem_q <= mem_d;
            wr_q  <= wr_d;
            rd_q  <= rd_d;
            cnt_q <= cnt_d;
        end
    end

    assign dout  = mem_q[rd_q];
    assign level = cnt_q;

endmodule

// File: rtl/rng_fill_ctrl.sv
module rng_fill_ctrl #(
    parameter int                               FIFO_DEPTH = 16,
    parameter logic [rng_fill_pkg::LFSR_W-1:0]  SEED       = 64'h0123_4567_89AB_CDEF
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [rng_fill_pkg::ADDR_W-1:0] addr,
    input  logic                            wr_en,
    input  logic [rng_fill_pkg::WORD_W-1:0] wr_data,
    input  logic                            rd_en,
    output logic [rng_fill_pkg::WORD_W-1:0] rd_data,
    output logic                            irq
);
    import rng_fill_pkg::*;

    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    ctl_state_t        st_d, st_q;
    logic [WORD_W-1:0] rand_word;
    logic [WORD_W-1:0] fifo_dout;
    logic [LVL_W-1:0]  fifo_level;
    logic              fifo_full, fifo_empty;
    logic              fifo_push, fifo_pop;
    logic [WORD_W-1:0] stat_word;
    logic              unused_wr_bits;

    assign unused_wr_bits = ^wr_data[WORD_W-1:CTL_CLR+1];

    rng_lfsr64 #(.SEED(SEED)) u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .word (rand_word)
    );

    rng_word_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W), .LVL_W(LVL_W)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (fifo_push),
        .din  (rand_word),
        .pop  (fifo_pop),
        .dout (fifo_dout),
        .level(fifo_level),
        .full (fifo_full),
        .empty(fifo_empty)
    );

    always_comb begin
        stat_word = '0;
        stat_word[STAT_LVL_LSB +: LVL_W] = fifo_level;
        stat_word[STAT_ERR]  = st_q.err;
        stat_word[STAT_FULL] = fifo_full;
    end

    always_comb begin
        st_d      = st_q;
        fifo_pop  = 1'b0;

        // cadence: free-running while started, wraps every 2**CAD_W cycles
        st_d.cnt  = st_q.start ? st_q.cnt + 1'b1 : '0;
        fifo_push = st_q.start && (st_q.cnt == '1) && !fifo_full;

        if (wr_en && addr == OFS_CTRL) begin
            st_d.start = wr_data[CTL_START];
            st_d.ie    = wr_data[CTL_IE];
            if (wr_data[CTL_CLR]) begin
                st_d.err = 1'b0;
                st_d.irq = 1'b0;
            end
        end

        if (rd_en) begin
            unique case (addr)
                OFS_CTRL: begin
                    st_d.rdata = '0;
                    st_d.rdata[CTL_START] = st_q.start;
                    st_d.rdata[CTL_IE]    = st_q.ie;
                end
                OFS_STAT: st_d.rdata = stat_word;
                OFS_DATA: begin
                    if (!fifo_empty) begin
                        fifo_pop   = 1'b1;
                        st_d.rdata = fifo_dout;
                    end else begin
                        st_d.rdata = '0;
                        st_d.err   = 1'b1;
                        if (st_q.ie) st_d.irq = 1'b1;
                    end
                end
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdata;
    assign irq     = st_q.irq;

endmodule

// File: rtl/rng_fill_ctrl_chk.sv
module rng_fill_ctrl_chk #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [rng_fill_pkg::ADDR_W-1:0] addr,
    input logic                            wr_en,
    input logic                            clr_bit,
    input logic                            rd_en,
    input logic [rng_fill_pkg::WORD_W-1:0] rd_data,
    input logic                            irq,
    input logic [LVL_W-1:0]                level,
    input logic                            full,
    input logic                            empty,
    input logic                            start,
    input logic                            push
);
    import rng_fill_pkg::*;

    logic data_rd, clr_wr;
    assign data_rd = rd_en && (addr == OFS_DATA);
    assign clr_wr  = wr_en && (addr == OFS_CTRL) && clr_bit;

    // input rule: one access per cycle
    assert_single_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

    assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    assert_idle_no_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> level <= $past(level));

    assert_full_no_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> level <= $past(level));

    assert_pop_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !empty && !push) |=> level == $past(level) - 1'b1);

    assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && empty) |=> rd_data == '0);

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(data_rd && empty));

    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);

    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !irq);

endmodule

bind rng_fill_ctrl rng_fill_ctrl_chk #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .wr_en  (wr_en),
    .clr_bit(wr_data[2]),
    .rd_en  (rd_en),
    .rd_data(rd_data),
    .irq    (irq),
    .level  (fifo_level),
    .full   (fifo_full),
    .empty  (fifo_empty),
    .start  (st_q.start),
    .push   (fifo_push)
);

// File: tb/rng_fill_ctrl_bench.sv
`timescale 1ns/1ps
module rng_fill_ctrl_bench;

    localparam logic [63:0] SEED  = 64'h0123_4567_89AB_CDEF;
    localparam int          WD_CY = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;   // index of the next clock edge after reset release
    int ew, er;

    always #2.5 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    rng_fill_ctrl u_rng_fill_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_en  (rd_en),
        .rd_data(rd_data),
        .irq    (irq)
    );

    function automatic logic [31:0] exp_word(int e);
        logic [63:0] s;
        s = SEED;
        for (int i = 0; i < e; i++) s = {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
        return s[63:32] ^ s[31:0];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic idle_until(int e);
        while (cyc < e) begin @(posedge clk); #1; end
    endtask

    function automatic logic [31:0] lvl(logic [31:0] s);
        return {27'd0, s[12:8]};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 rd_data", rd_data, 32'd0);
        rd(4'h0, v); chk("R1 control", v, 32'd0);
        rd(4'h4, v); chk("R1 status", v, 32'd0);
    endtask

    task automatic t_idle();
        logic [31:0] v;
        idle_until(cyc + 600);
        rd(4'h4, v); chk("R2 level while stopped", lvl(v), 32'd0);
    endtask

    task automatic t_empty_no_ie();
        logic [31:0] v;
        rd(4'h8, v); chk("R8 empty read data", v, 32'd0);
        rd(4'h4, v);
        chk("R8 error flag", {31'd0, v[1]}, 32'd1);
        chk("R8 level unchanged", lvl(v), 32'd0);
        chk("R9 irq low without enable", {31'd0, irq}, 32'd0);
        wr(4'h0, 32'h4);
        rd(4'h4, v); chk("R10 error cleared", {31'd0, v[1]}, 32'd0);
        rd(4'h0, v); chk("R10 clear bit reads 0", v, 32'd0);
    endtask

    task automatic t_empty_ie();
        logic [31:0] v;
        wr(4'h0, 32'h2);
        rd(4'h8, v); chk("R9 empty read data", v, 32'd0);
        chk("R9 irq raised", {31'd0, irq}, 32'd1);
        idle_until(cyc + 5);
        chk("R10 irq sticky", {31'd0, irq}, 32'd1);
        wr(4'h0, 32'h6);
        chk("R10 irq cleared", {31'd0, irq}, 32'd0);
        rd(4'h0, v); chk("R10 control readback", v, 32'd2);
    endtask

    task automatic t_cadence_and_full();
        logic [31:0] v;
        ew = cyc;
        wr(4'h0, 32'h3);
        idle_until(ew + 256); rd(4'h4, v); chk("R3 no push before boundary", lvl(v), 32'd0);
        rd(4'h4, v); chk("R3 first push", lvl(v), 32'd1);
        idle_until(ew + 513); rd(4'h4, v); chk("R3 second push", lvl(v), 32'd2);
        rd(4'h8, v); chk("R4 first word", v, exp_word(ew + 256));
        rd(4'h8, v); chk("R7 back-to-back word", v, exp_word(ew + 512));
        rd(4'h4, v); chk("R7 drained level", lvl(v), 32'd0);
        // pushes k=3..18 fill the queue; k=19 is skipped
        idle_until(ew + 4869); rd(4'h4, v);
        chk("R5 level at full", lvl(v), 32'd16);
        chk("R5 full flag", {31'd0, v[0]}, 32'd1);
        rd(4'h8, v); chk("R7 oldest word", v, exp_word(ew + 768));
        rd(4'h4, v);
        chk("R6 level after pop", lvl(v), 32'd15);
        chk("R5 full flag cleared", {31'd0, v[0]}, 32'd0);
        idle_until(ew + 5120); rd(4'h4, v); chk("R6 wait for boundary", lvl(v), 32'd15);
        rd(4'h4, v); chk("R6 resumed push", lvl(v), 32'd16);
        for (int k = 4; k <= 18; k++) begin
            rd(4'h8, v); chk("R7 drain order", v, exp_word(ew + 256 * k));
        end
        rd(4'h8, v); chk("R6 resumed word", v, exp_word(ew + 5120));
        rd(4'h4, v); chk("R7 empty after drain", v, 32'd0);
        chk("R9 no irq on normal reads", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_stop_restart();
        logic [31:0] v;
        wr(4'h0, 32'h2);
        idle_until(cyc + 700);
        rd(4'h4, v); chk("R11 no push after stop", lvl(v), 32'd0);
        er = cyc;
        wr(4'h0, 32'h3);
        idle_until(er + 256); rd(4'h4, v); chk("R11 restart waits full period", lvl(v), 32'd0);
        rd(4'h4, v); chk("R11 restart push", lvl(v), 32'd1);
        rd(4'h8, v); chk("R4 word after restart", v, exp_word(er + 256));
        rd(4'h0, v); chk("R11 control readback", v, 32'd3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_idle();
        t_empty_no_ie();
        t_empty_ie();
        t_cadence_and_full();
        t_stop_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(WD_CY * 5.0);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule